// File: doc/BRIEF.md
# Multi-Slot Serial Audio Receiver

This block takes a serial audio stream, made of a bit clock, a frame clock and two data lines, and turns it into four parallel 24-bit sample registers. It runs in one of two layouts. In the stereo-pair layout each data line carries one left/right pair, and the two halves of a frame are marked by the level of the frame clock. In the packed layout a single line carries all four channels in a 128-bit-clock frame, and the other line is not read. Either layout accepts left-justified timing, where the MSB arrives together with the frame-clock change, or I2S timing, where the MSB arrives one bit clock later.

The serial inputs are sampled by the block's own system clock through a configurable synchronizer, so the bit clock must be several times slower than `clk`. The four output registers change together, only at the start of the frame after the one that filled them, and a one-cycle strobe marks that change. The layout is latched at each frame start, so a change of `cfg_tdm` mid-frame has no effect until the next frame. A packed-layout request made together with the quad-rate flag is refused: the block stays in the stereo-pair layout and raises an error flag.

Top module: `tdm_audio_rx`

## Requirements
- R1: While `rst` is high, `ch0`..`ch3` are zero and `frame_valid` and `mode_err` are low.
- R2: Data and frame clock are sampled on rising bit-clock edges. A frame starts at the edge where the frame clock is first seen at its left level: high when `cfg_i2s`=0 (left-justified), low when `cfg_i2s`=1 (I2S).
- R3: In left-justified timing the MSB of a sample is the bit taken at the edge where the frame clock changes. In I2S timing it is the bit taken one bit clock later. Each sample is 24 bits, MSB first, and any further bits of its slot are ignored.
- R4: In the stereo-pair layout (`cfg_tdm`=0) `sd0` carries ch0 (left half) and ch1 (right half), and `sd1` carries ch2 (left) and ch3 (right). Each half is 32 bit clocks long and begins at a frame-clock change.
- R5: In the packed layout (`cfg_tdm`=1, `cfg_quad`=0) a frame is 128 bit clocks long and holds four 32-bit slots on `sd0`. Counted from the frame start, the slots fill ch0, ch1, ch2 and ch3 in that order.
- R6: In the packed layout the value on `sd1` has no effect on any output.
- R7: All four channel outputs change only in the cycle in which `frame_valid` is high. `frame_valid` is high for exactly one `clk` cycle at each frame start that follows a complete frame, and it then presents that frame's samples. The first frame start after reset produces no strobe.
- R8: With `cfg_tdm`=1 and `cfg_quad`=1 the block decodes in the stereo-pair layout, and `mode_err` is high one `clk` cycle after those inputs appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial input |
| rst | input | 1 | Synchronous reset, active high |
| cfg_tdm | input | 1 | Request for the packed four-channel layout |
| cfg_i2s | input | 1 | 0 = left-justified timing, 1 = I2S timing |
| cfg_quad | input | 1 | Quad sampling-rate flag; blocks the packed layout |
| bclk | input | 1 | Serial bit clock |
| fclk | input | 1 | Serial frame clock |
| sd0 | input | 1 | First serial data line |
| sd1 | input | 1 | Second serial data line |
| ch0 | output | DATA_W | Channel 0 sample (first left) |
| ch1 | output | DATA_W | Channel 1 sample (first right) |
| ch2 | output | DATA_W | Channel 2 sample (second left) |
| ch3 | output | DATA_W | Channel 3 sample (second right) |
| frame_valid | output | 1 | One-cycle strobe when all four channels update |
| mode_err | output | 1 | Packed layout requested at quad rate |

## Verification
Some properties are checked on every cycle: the strobe lasts a single cycle and always follows a detected frame start, the channel outputs never move outside a strobe cycle, and a frame start under the quad-rate flag never latches the packed layout. Other behaviour can only be shown by the bench's scenarios. These are bit ordering, slot-to-channel mapping, the one-bit offset of I2S timing, the split of each line across the frame-clock halves, and the fact that the second line is ignored in the packed layout. The bench drives known frames in every layout and timing combination, including corner sample values, and compares every committed frame with a behavioural queue.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
   localparam int unsigned CHANNELS = 4;
   localparam int unsigned LINES    = 2;
   localparam int unsigned RAW_W    = 4;   // {bclk, fclk, sd0, sd1}
endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out,
   output logic             msb_rise
);
   logic msb_prev;

   if (WIDTH < 1) begin : g_bad_width
      $error("tdm_rx_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_direct
      assign d_out = d_in;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign d_out = stg[STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (rst) msb_prev <= 1'b0;
      else     msb_prev <= d_out[WIDTH-1];
   end

   assign msb_rise = d_out[WIDTH-1] & ~msb_prev;
endmodule

// File: rtl/tdm_rx_tracker.sv
module tdm_rx_tracker #(
   parameter int unsigned POS_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample,
   input  logic             fclk_s,
   input  logic             fmt_i2s,
   input  logic             tdm_req,
   output logic [POS_W-1:0] cur_pos,
   output logic             start,
   output logic             left,
   output logic             tdm_now,
   output logic             tdm_lat
);
   logic             fclk_prev;
   logic [POS_W-1:0] pos_q;
   logic             chg;
   logic             restart;

   assign left    = fmt_i2s ? ~fclk_s : fclk_s;
   assign chg     = sample & (fclk_s ^ fclk_prev);
   assign start   = chg & left;
   assign tdm_now = start ? tdm_req : tdm_lat;
   assign restart = tdm_now ? start : chg;
   assign cur_pos = restart ? '0 : pos_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         fclk_prev <= 1'b0;
         pos_q     <= '0;
         tdm_lat   <= 1'b0;
      end else if (sample) begin
         fclk_prev <= fclk_s;
         pos_q     <= (&cur_pos) ? cur_pos : cur_pos + 1'b1;
         if (start) tdm_lat <= tdm_req;
      end
   end
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture
   import tdm_rx_pkg::*;
#(
   parameter int unsigned DATA_W    = 24,
   parameter int unsigned SLOT_BITS = 32,
   parameter int unsigned POS_W     = 8
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             sample,
   input  logic                             start,
   input  logic                             tdm,
   input  logic                             i2s,
   input  logic                             left,
   input  logic [POS_W-1:0]                 cur_pos,
   input  logic                             d0,
   input  logic                             d1,
   output logic [CHANNELS-1:0][DATA_W-1:0]  ch,
   output logic                             valid
);
   localparam int unsigned BIT_W  = $clog2(SLOT_BITS);
   localparam int unsigned SLOT_W = POS_W - BIT_W;

   if (DATA_W > SLOT_BITS) begin : g_bad_data
      $error("tdm_rx_capture: DATA_W exceeds SLOT_BITS");
   end
   if ((1 << BIT_W) != SLOT_BITS) begin : g_bad_slot
      $error("tdm_rx_capture: SLOT_BITS must be a power of two");
   end

   logic [POS_W-1:0]  eidx;
   logic              lead_ok;
   logic [SLOT_W-1:0] slot;
   logic [BIT_W-1:0]  bitn;
   logic [BIT_W-1:0]  sh_idx;
   logic              take;
   logic              commit;
   logic              armed;

   assign eidx    = cur_pos - {{(POS_W-1){1'b0}}, i2s};
   assign lead_ok = cur_pos >= {{(POS_W-1){1'b0}}, i2s};
   assign slot    = eidx[POS_W-1:BIT_W];
   assign bitn    = eidx[BIT_W-1:0];
   assign sh_idx  = BIT_W'(DATA_W - 1) - bitn;
   assign take    = sample & lead_ok & ({1'b0, bitn} < (BIT_W+1)'(DATA_W));
   assign commit  = sample & start & armed;

   for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      logic              wr;
      logic              bit_in;
      logic [DATA_W-1:0] sh_q;
      logic [DATA_W-1:0] out_q;

      assign wr     = take & (tdm ? (slot == SLOT_W'(c))
                                  : ((slot == '0) && (left == ((c % 2) == 0))));
      assign bit_in = (tdm || (c < 2)) ? d0 : d1;

      always_ff @(posedge clk) begin
         if (rst) begin
            sh_q  <= '0;
            out_q <= '0;
         end else begin
            if (commit) out_q <= sh_q;
            if (wr)     sh_q[sh_idx] <= bit_in;
         end
      end
      assign ch[c] = out_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         armed <= 1'b0;
         valid <= 1'b0;
      end else begin
         valid <= commit;
         if (sample && start) armed <= 1'b1;
      end
   end

   // R7: a strobe is only ever the consequence of a frame start seen by the tracker
   a_r7_strobe_after_start: assert property (@(posedge clk) disable iff (rst)
      valid |-> $past(start));
endmodule

// File: rtl/tdm_audio_rx.sv
module tdm_audio_rx
   import tdm_rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 24,
   parameter int unsigned SLOT_BITS   = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_tdm,
   input  logic              cfg_i2s,
   input  logic              cfg_quad,
   input  logic              bclk,
   input  logic              fclk,
   input  logic              sd0,
   input  logic              sd1,
   output logic [DATA_W-1:0] ch0,
   output logic [DATA_W-1:0] ch1,
   output logic [DATA_W-1:0] ch2,
   output logic [DATA_W-1:0] ch3,
   output logic              frame_valid,
   output logic              mode_err
);
   localparam int unsigned FRAME_BITS = CHANNELS * SLOT_BITS;
   localparam int unsigned POS_W      = $clog2(FRAME_BITS) + 1;

   logic [RAW_W-1:0]                raw_s;
   logic                            sample;
   logic [POS_W-1:0]                cur_pos;
   logic                            trk_start;
   logic                            trk_left;
   logic                            tdm_now;
   logic                            tdm_lat;
   logic [CHANNELS-1:0][DATA_W-1:0] ch_w;

   tdm_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(RAW_W)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .d_in     ({bclk, fclk, sd0, sd1}),
      .d_out    (raw_s),
      .msb_rise (sample)
   );

   tdm_rx_tracker #(.POS_W(POS_W)) u_trk (
      .clk     (clk),
      .rst     (rst),
      .sample  (sample),
      .fclk_s  (raw_s[2]),
      .fmt_i2s (cfg_i2s),
      .tdm_req (cfg_tdm & ~cfg_quad),
      .cur_pos (cur_pos),
      .start   (trk_start),
      .left    (trk_left),
      .tdm_now (tdm_now),
      .tdm_lat (tdm_lat)
   );

   tdm_rx_capture #(.DATA_W(DATA_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .sample  (sample),
      .start   (trk_start),
      .tdm     (tdm_now),
      .i2s     (cfg_i2s),
      .left    (trk_left),
      .cur_pos (cur_pos),
      .d0      (raw_s[1]),
      .d1      (raw_s[0]),
      .ch      (ch_w),
      .valid   (frame_valid)
   );

   always_ff @(posedge clk) begin
      if (rst) mode_err <= 1'b0;
      else     mode_err <= cfg_tdm & cfg_quad;
   end

   assign ch0 = ch_w[0];
   assign ch1 = ch_w[1];
   assign ch2 = ch_w[2];
   assign ch3 = ch_w[3];

   // R7: the strobe never spans two cycles
   a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
      frame_valid |=> !frame_valid);

   // R7: channel outputs move only together with the strobe
   a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
      !frame_valid |-> $stable(ch_w));

   // R8: a frame start under the quad-rate flag never latches the packed layout
   a_r8_no_pack_at_quad: assert property (@(posedge clk) disable iff (rst)
      (trk_start && cfg_quad) |=> !tdm_lat);
endmodule

// File: tb/tdm_audio_rx_tb.sv
module tdm_audio_rx_tb;
   localparam int DW = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_tdm = 1'b0, cfg_i2s = 1'b0, cfg_quad = 1'b0;
   logic bclk = 1'b0, fclk = 1'b0, sd0 = 1'b0, sd1 = 1'b0;
   logic [DW-1:0] ch0, ch1, ch2, ch3;
   logic frame_valid, mode_err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_tag = "R7";
   logic [4*DW-1:0] expq [$];
   logic [4*DW-1:0] prev_ch = '0;

   always #2.5 clk = ~clk;

   tdm_audio_rx u_dut (
      .clk(clk), .rst(rst), .cfg_tdm(cfg_tdm), .cfg_i2s(cfg_i2s), .cfg_quad(cfg_quad),
      .bclk(bclk), .fclk(fclk), .sd0(sd0), .sd1(sd1),
      .ch0(ch0), .ch1(ch1), .ch2(ch2), .ch3(ch3),
      .frame_valid(frame_valid), .mode_err(mode_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [4*DW-1:0] act,
                      input logic [4*DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference, compared every clock
   always @(negedge clk) begin
      cycles++;
      if (rst) begin
         prev_ch = '0;
      end else begin
         if (frame_valid) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R7 unexpected strobe", {ch0, ch1, ch2, ch3}, '0);
            end else begin
               chk({ch0, ch1, ch2, ch3} == expq[0], cur_tag, {ch0, ch1, ch2, ch3}, expq[0]);
               void'(expq.pop_front());
            end
         end else begin
            chk({ch0, ch1, ch2, ch3} == prev_ch, "R7 hold", {ch0, ch1, ch2, ch3}, prev_ch);
         end
         prev_ch = {ch0, ch1, ch2, ch3};
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic tick(input logic f, input logic d0, input logic d1);
      @(negedge clk);
      bclk = 1'b0; fclk = f; sd0 = d0; sd1 = d1;
      repeat (3) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
   endtask

   task automatic send_frame(input bit tdm, input bit i2s,
                             input logic [DW-1:0] c0, input logic [DW-1:0] c1,
                             input logic [DW-1:0] c2, input logic [DW-1:0] c3,
                             input bit push);
      logic [DW-1:0] cs [4];
      logic l0 [128];
      logic l1 [128];
      int nb;
      cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
      nb = tdm ? 128 : 64;
      for (int k = 0; k < nb; k++) begin
         int s = k / 32;
         int b = k % 32;
         if (tdm) begin
            l0[k] = (b < DW) ? cs[s][DW-1-b] : 1'b0;
            l1[k] = 1'($urandom);                     // R6: noise on the unused line
         end else begin
            l0[k] = (b < DW) ? cs[s][DW-1-b] : 1'b0;
            l1[k] = (b < DW) ? cs[2+s][DW-1-b] : 1'b0;
         end
      end
      for (int k = 0; k < nb; k++) begin
         logic lft = (k < nb / 2);
         int idx = i2s ? k - 1 : k;
         tick(i2s ? ~lft : lft, (idx < 0) ? 1'b0 : l0[idx],
              (idx < 0) ? 1'($urandom) : l1[idx]);
      end
      if (push) expq.push_back({c0, c1, c2, c3});
   endtask

   task automatic run_phase(input bit tdm, input bit i2s, input bit quad,
                            input int nfr, input string tag);
      bit packed_mode = tdm & ~quad;
      rst = 1'b1;
      cfg_tdm = tdm; cfg_i2s = i2s; cfg_quad = quad;
      bclk = 1'b0; fclk = i2s; sd0 = 1'b0; sd1 = 1'b0;
      expq.delete();
      repeat (4) @(negedge clk);
      chk({ch0, ch1, ch2, ch3, frame_valid, mode_err} == '0, "R1 reset state",
          {ch0, ch1, ch2, ch3}, '0);
      @(negedge clk);
      rst = 1'b0;
      cur_tag = tag;
      repeat (4) tick(i2s, 1'b0, 1'b0);
      for (int f = 0; f < nfr; f++) begin
         if (f == 0)
            send_frame(packed_mode, i2s, 24'h800000, 24'h7FFFFF, 24'hFFFFFF, 24'h000001, 1'b1);
         else
            send_frame(packed_mode, i2s, DW'($urandom), DW'($urandom), DW'($urandom),
                       DW'($urandom), 1'b1);
      end
      send_frame(packed_mode, i2s, '0, '0, '0, '0, 1'b0);
      repeat (8) @(negedge clk);
      chk(expq.size() == 0, "R7 every frame committed", 96'(expq.size()), '0);
      chk(mode_err == (tdm & quad), "R8 mode_err", 96'(mode_err), 96'(tdm & quad));
   endtask

   initial begin
      run_phase(1'b0, 1'b0, 1'b0, 3, "R2 R3 R4 pair/left-justified");
      run_phase(1'b0, 1'b1, 1'b0, 3, "R2 R3 R4 pair/I2S");
      run_phase(1'b1, 1'b0, 1'b0, 3, "R5 R6 packed/left-justified");
      run_phase(1'b1, 1'b1, 1'b0, 3, "R5 R6 packed/I2S");
      run_phase(1'b1, 1'b0, 1'b1, 3, "R8 fallback to pair layout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule